// File: doc/BRIEF.md
# Asynchronous SRAM Host Cycle Controller

This block sits between a synchronous host and an asynchronous byte-wide static memory with a 21-bit address. The host raises a request carrying an address, a read/write select and write data. It holds the request steady until the controller answers with a one-cycle ready pulse; on reads, the returned byte comes with that pulse. On the memory side the controller sequences the active-low chip, write and output enables. It also drives the address, drives the write data with a separate driver-enable (the chip's pad ring builds the tri-state), and samples the returned read byte.

All memory timing is set in nanoseconds by parameters and converted to whole clock cycles by rounding up against a clock-period parameter. Writes are shaped so that write-enable both opens and closes the write while chip-enable stays low around it: chip-enable falls with or before write-enable and rises only after write-enable has gone high again. Output-enable stays high for the whole write. The controller only drives the data lines while write-enable is low. After a read it waits for the memory's outputs to float before it drives the data lines again.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: After reset, mem_ce_n, mem_we_n and mem_oe_n are 1, and mem_dq_oe and host_ready are 0. They stay so while req_valid is 0.
- R2: A write holds mem_ce_n=0 and mem_we_n=0 for exactly WP cycles, then mem_we_n=1 with mem_ce_n=0 for exactly WR cycles, then mem_ce_n=1. WP is the largest of the rounded-up write pulse, address-to-end-of-write and data-valid-to-end times (55, 65, 30 ns; at least 1). WR is the larger of the rounded-up recovery (5 ns, at least 1) and the write-cycle time (70 ns) minus WP.
- R3: mem_dq_oe is 1 exactly in the cycles where mem_we_n is 0, and mem_oe_n is 1 and mem_ce_n is 0 in every such cycle.
- R4: A read holds mem_ce_n=0, mem_oe_n=0 and mem_we_n=1 for exactly RA cycles. RA is the largest of the rounded-up read-cycle, address-access and output-enable access times (70, 70, 35 ns). mem_dq_i is captured at the clock edge that ends the last such cycle and appears on host_rdata with the ready pulse. host_rdata then holds until the next read completes.
- R5: mem_addr is stable across every pair of consecutive cycles in which mem_ce_n is 0. It therefore changes only when the previous cycle had mem_ce_n=1.
- R6: After a read, mem_oe_n stays 1 for at least TA full cycles before mem_dq_oe rises, where TA is the rounded-up output-disable time (25 ns).
- R7: host_ready pulses for exactly one cycle per request, in the cycle where mem_ce_n returns to 1. A new request is taken only when req_valid is 1 and host_ready is 0. A read's ready appears RA+1 cycles after the request is raised from an idle controller.
- R8: During the write pulse, mem_addr equals req_addr and mem_dq_o equals req_wdata of the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present; held until host_ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Byte address |
| req_wdata | input | 8 | Write byte |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Last byte read |
| mem_addr | output | 21 | Memory address lines |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_o | output | 8 | Data driven toward memory |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_i | input | 8 | Data returned from memory |

## Verification
The bound checker watches every cycle for the strobe relations that prevent contention and corruption. It confirms that the driver tracks write-enable and that output-enable never overlaps a write. It confirms that chip-enable never rises while write-enable is low, that the address never moves under a low chip-enable, that the write pulse has its full length, that the output-disable gap comes before the driver turns on, and that ready lasts one cycle. Only the bench's scenarios can show that the data actually arrives. A memory model that commits on the rising write-enable and returns corrupt bytes before the access time has run out exposes early capture, wrong data routing and a lost read value. The bench also measures recovery length and read latency, and covers read-then-write turnaround at extreme addresses.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_WR_PULSE,
    PH_WR_RECOV,
    PH_RD_ACCESS
  } phase_e;

  // Whole clock cycles needed to cover a time given in ns.
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_cnt.sv
module sram_phase_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= load_val;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/sram_turnaround.sv
module sram_turnaround #(
  parameter int W      = 4,
  parameter int TA_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_done,
  output logic bus_free
);
  logic [W-1:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n)          gap <= '0;
    else if (rd_done)    gap <= W'(TA_CYC);
    else if (gap != '0)  gap <= gap - 1'b1;
  end

  assign bus_free = (gap == '0);
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (!rst_n)    dout <= '0;
    else if (take) dout <= din;
  end
endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int DATA_W   = 8,
  parameter int CLK_NS   = 10,
  parameter int T_WC_NS  = 70,
  parameter int T_WP_NS  = 55,
  parameter int T_AW_NS  = 65,
  parameter int T_DW_NS  = 30,
  parameter int T_WR_NS  = 5,
  parameter int T_RC_NS  = 70,
  parameter int T_AA_NS  = 70,
  parameter int T_OE_NS  = 35,
  parameter int T_OHZ_NS = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              host_ready,
  output logic [DATA_W-1:0] host_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);
  // Cycle counts derived from the nanosecond parameters.
  localparam int WP_CYC = max2(1, max2(ns_to_cyc(T_WP_NS, CLK_NS),
                                max2(ns_to_cyc(T_AW_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS))));
  localparam int WR_CYC = max2(max2(1, ns_to_cyc(T_WR_NS, CLK_NS)),
                               ns_to_cyc(T_WC_NS, CLK_NS) - WP_CYC);
  localparam int RA_CYC = max2(1, max2(ns_to_cyc(T_RC_NS, CLK_NS),
                                max2(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS))));
  localparam int TA_CYC = ns_to_cyc(T_OHZ_NS, CLK_NS);
  localparam int CNT_W  = $clog2(max2(max2(WP_CYC, WR_CYC), max2(RA_CYC, TA_CYC)) + 1) + 1;

  phase_e             phase;
  logic               ph_expired;
  logic               bus_free;
  logic               ld_en;
  logic [CNT_W-1:0]   ld_val;

  // Named events, shared by the sequencer and the checker.
  logic accept, start_wr, start_rd, wr_pulse_end, wr_end, rd_end;

  assign accept       = (phase == PH_IDLE) && req_valid && !host_ready &&
                        (!req_write || bus_free);
  assign start_wr     = accept && req_write;
  assign start_rd     = accept && !req_write;
  assign wr_pulse_end = (phase == PH_WR_PULSE)  && ph_expired;
  assign wr_end       = (phase == PH_WR_RECOV)  && ph_expired;
  assign rd_end       = (phase == PH_RD_ACCESS) && ph_expired;

  always_comb begin
    ld_en = start_wr || start_rd || wr_pulse_end;
    if (start_wr)      ld_val = CNT_W'(WP_CYC - 1);
    else if (start_rd) ld_val = CNT_W'(RA_CYC - 1);
    else               ld_val = CNT_W'(WR_CYC - 1);
  end

  sram_phase_cnt #(.W(CNT_W)) phase_cnt_i (
    .clk(clk), .rst_n(rst_n), .load(ld_en), .load_val(ld_val), .expired(ph_expired)
  );

  sram_turnaround #(.W(CNT_W), .TA_CYC(TA_CYC)) turn_i (
    .clk(clk), .rst_n(rst_n), .rd_done(rd_end), .bus_free(bus_free)
  );

  sram_rd_capture #(.DATA_W(DATA_W)) cap_i (
    .clk(clk), .rst_n(rst_n), .take(rd_end), .din(mem_dq_i), .dout(host_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      mem_ce_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
      mem_addr   <= '0;
      mem_dq_o   <= '0;
      host_ready <= 1'b0;
    end else begin
      host_ready <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (accept) begin
            mem_addr <= req_addr;
            mem_ce_n <= 1'b0;
            if (req_write) begin
              mem_dq_o  <= req_wdata;
              mem_we_n  <= 1'b0;
              mem_dq_oe <= 1'b1;
              phase     <= PH_WR_PULSE;
            end else begin
              mem_oe_n  <= 1'b0;
              phase     <= PH_RD_ACCESS;
            end
          end
        end
        PH_WR_PULSE: begin
          if (wr_pulse_end) begin
            mem_we_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
            phase     <= PH_WR_RECOV;
          end
        end
        PH_WR_RECOV: begin
          if (wr_end) begin
            mem_ce_n   <= 1'b1;
            host_ready <= 1'b1;
            phase      <= PH_IDLE;
          end
        end
        PH_RD_ACCESS: begin
          if (rd_end) begin
            mem_ce_n   <= 1'b1;
            mem_oe_n   <= 1'b1;
            host_ready <= 1'b1;
            phase      <= PH_IDLE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk #(
  parameter int ADDR_W = 21,
  parameter int WP_CYC = 7,
  parameter int TA_CYC = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe,
  input logic              rd_end
);
  logic [31:0] we_run;
  logic [31:0] oeh_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_run  <= '0;
      oeh_run <= 32'hFFFF;
    end else begin
      we_run  <= mem_we_n ? '0 : we_run + 1'b1;
      if (!mem_oe_n)               oeh_run <= '0;
      else if (oeh_run != 32'hFFFF) oeh_run <= oeh_run + 1'b1;
    end
  end

  a_r2_we_ends_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |-> $past(mem_we_n));
  a_r2_pulse_length: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> we_run == 32'(WP_CYC));
  a_r3_drive_with_we: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe == !mem_we_n);
  a_r3_oe_off_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n));
  a_r4_read_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_ce_n));
  a_r4_capture_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rd_end |=> (host_ready && mem_oe_n));
  a_r5_addr_still: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));
  a_r6_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> oeh_run >= 32'(TA_CYC));
  a_r7_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |=> !host_ready);
  a_r7_ready_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> mem_ce_n);
endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(
  .ADDR_W(ADDR_W), .WP_CYC(WP_CYC), .TA_CYC(TA_CYC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .host_ready(host_ready), .mem_addr(mem_addr),
  .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .mem_dq_oe(mem_dq_oe), .rd_end(rd_end)
);

// File: tb/sram_cycle_ctrl_tb.sv
module sram_cycle_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 21;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          host_ready;
  logic [DW-1:0] host_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_o;
  logic [DW-1:0] mem_dq_i = 8'h5A;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_cycle_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .host_ready(host_ready),
    .host_rdata(host_rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // Timing expectations restated by counting up in clock periods.
  function automatic int cover_ns(input int ns);
    int c = 0;
    while (c * CLK_PERIOD < ns) c++;
    return c;
  endfunction
  function automatic int biggest(input int a, input int b, input int c);
    int m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction
  localparam int EXP_WP = 7;
  int exp_wp, exp_wr, exp_ra, exp_ta;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  bit mon_on = 0;

  task automatic check(input bit ok, input string tag, input longint got, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  logic [DW-1:0] model   [int];
  logic [DW-1:0] ref_mem [int];
  logic [AW-1:0] exp_addr;
  logic [DW-1:0] exp_data;

  // Monitor and memory model, all on the falling edge.
  int we_run = 0, rec_run = 0, oe_run = 0, oeh_run = 1000, rd_age = 0;
  bit in_rec = 0;
  logic p_ce = 1, p_we = 1, p_oe = 1, p_dqoe = 0, p_rdy = 0;
  logic [AW-1:0] p_addr = '0;
  logic [DW-1:0] p_dq = '0;

  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      if (mem_dq_oe != !mem_we_n || (!mem_we_n && (!mem_oe_n || mem_ce_n)))
        check(0, "R3 driver/strobe overlap", {mem_dq_oe, mem_we_n, mem_oe_n}, 3'b101);
      if (!mem_we_n && (mem_addr != exp_addr || mem_dq_o != exp_data))
        check(0, "R8 write addr/data", {mem_addr, mem_dq_o}, {exp_addr, exp_data});
      if (!mem_ce_n && !p_ce && mem_addr != p_addr)
        check(0, "R5 addr moved under ce", mem_addr, p_addr);
      if (host_ready && p_rdy)
        check(0, "R7 ready longer than one cycle", 2, 1);
      if (mem_dq_oe && !p_dqoe)
        check(oeh_run >= exp_ta, "R6 turnaround gap", oeh_run, exp_ta);
      if (!mem_we_n) we_run++;
      else if (!p_we) begin
        check(we_run == exp_wp, "R2 write pulse length", we_run, exp_wp);
        model[int'(p_addr)] = p_dq;
        we_run = 0; in_rec = 1; rec_run = 0;
      end
      if (in_rec) begin
        if (!mem_ce_n && mem_we_n) rec_run++;
        else if (mem_ce_n) begin
          check(rec_run == exp_wr, "R2 write recovery length", rec_run, exp_wr);
          check(host_ready, "R7 ready with write deselect", host_ready, 1);
          in_rec = 0;
        end
      end
      if (!mem_oe_n) begin
        oe_run++; oeh_run = 0;
      end else begin
        if (!p_oe) check(oe_run == exp_ra, "R4 read strobe length", oe_run, exp_ra);
        oe_run = 0; oeh_run++;
      end
    end
    // memory returns corrupt data until the access time has elapsed
    if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
      rd_age++;
      if (rd_age >= exp_ra)
        mem_dq_i = model.exists(int'(mem_addr)) ? model[int'(mem_addr)] : 8'h00;
      else
        mem_dq_i = ~(model.exists(int'(mem_addr)) ? model[int'(mem_addr)] : 8'h00);
    end else begin
      rd_age = 0; mem_dq_i = 8'h5A;
    end
    p_ce = mem_ce_n; p_we = mem_we_n; p_oe = mem_oe_n; p_dqoe = mem_dq_oe;
    p_rdy = host_ready; p_addr = mem_addr; p_dq = mem_dq_o;
  end

  // Called at a falling edge; returns at the falling edge showing ready.
  task automatic wait_ready(output int lat);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!host_ready && lat < 200);
    if (!host_ready) check(0, "R7 ready never came", 0, 1);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int lat;
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    exp_addr = a; exp_data = d; ref_mem[int'(a)] = d;
    wait_ready(lat);
    req_valid = 0;
  endtask

  task automatic do_read(input logic [AW-1:0] a);
    int lat, want_lat;
    logic [DW-1:0] want;
    want_lat = exp_ra + 1 + (host_ready ? 1 : 0);
    want = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
    req_valid = 1; req_write = 0; req_addr = a;
    wait_ready(lat);
    req_valid = 0;
    check(host_rdata == want, "R4 read data", host_rdata, want);
    check(lat == want_lat, "R7 read latency", lat, want_lat);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] pool [6];
    logic [DW-1:0] held;
    exp_wp = biggest(cover_ns(55), cover_ns(65), cover_ns(30));
    if (exp_wp < 1) exp_wp = 1;
    exp_wr = biggest(1, cover_ns(5), cover_ns(70) - exp_wp);
    exp_ra = biggest(cover_ns(70), cover_ns(70), cover_ns(35));
    exp_ta = cover_ns(25);
    check(exp_wp == EXP_WP, "R2 derived pulse count", exp_wp, EXP_WP);
    void'($urandom(32'd20250611));

    repeat (4) @(negedge clk);
    rst_n = 1;
    mon_on = 1;
    // R1: idle state with no request
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !host_ready,
            "R1 idle strobes", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, host_ready}, 5'b11100);
    end

    // Directed: extremes of the address range, write then read back
    do_write('1, 8'hC3);
    do_write('0, 8'h3C);
    do_read('1);
    do_read('0);
    // R6: read immediately followed by writes
    do_write(21'h0AAAA, 8'h81);
    do_read(21'h0AAAA);
    do_write(21'h15555, 8'h7E);
    held = host_rdata;
    // R4: rdata holds over a write
    check(host_rdata == held && held == 8'h81, "R4 rdata held after write", host_rdata, 8'h81);
    do_read(21'h15555);
    // R7: no request for a while: nothing moves
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(mem_ce_n && !host_ready, "R7 no request no cycle", mem_ce_n, 1);
    end

    pool[0] = '0; pool[1] = '1; pool[2] = 21'h0AAAA;
    pool[3] = 21'h15555; pool[4] = 21'h100000; pool[5] = 21'h000001;
    for (int i = 0; i < 120; i++) begin
      logic [AW-1:0] a;
      a = (($urandom % 4) == 0) ? AW'($urandom) : pool[$urandom % 6];
      if ($urandom % 2) do_write(a, DW'($urandom));
      else              do_read(a);
      if (($urandom % 3) == 0) repeat ($urandom % 3) @(negedge clk);
    end
    repeat (5) @(negedge clk);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule